// File: doc/BRIEF.md
# GMII Receive Framer with CRC Check

This block sits behind an 8-bit GMII-style receive port, which gives one data-valid strobe and one data byte per clock. It turns each Ethernet frame into a stream of tagged bytes for on-chip logic. It looks for a lead-in of exactly seven 0x55 bytes followed by a 0xD5 delimiter and strips all eight of these bytes. It runs a reflected CRC-32 over every byte after the delimiter. It passes the payload to a valid/ready output, and each output byte carries a 2-bit code.

The block holds the last five received bytes in a short window. As a result, the four trailing check bytes are never forwarded. The block also knows which byte is the last payload byte when the strobe falls. The end code on that last byte reports the CRC result.

The output has a single register stage. If a frame byte must enter that register while it still holds a byte that is not being taken, the frame is truncated. The held byte stays as it is. One extra byte with the bad-end code closes the packet, and the rest of the frame is dropped.

Top module: `gmii_rx_framer`

## Requirements
- R1: Output codes are 0 = data, 1 = start of packet, 2 = good end and 3 = bad end. A packet of two or more bytes has one code-1 byte, then code-0 bytes, then one end-coded byte, with the payload bytes in wire order. A byte with code 1 only appears outside a packet, and a byte with code 0 only appears inside one.
- R2: The four bytes before the strobe falls are taken as the check field and are never forwarded. When the CRC (polynomial 0xEDB88320 reflected, initial value all ones, no final inversion) run over all bytes after the delimiter ends at 0xDEBB20E3, the last payload byte carries code 2. That byte is loaded in the clock after the strobe is sampled low.
- R3: A frame whose CRC does not end at the residue has its last payload byte marked with code 3.
- R4: A frame with exactly one payload byte gives a single output byte: that payload byte with the end code and no start-of-packet byte.
- R5: A frame with fewer than five bytes after the delimiter, including none at all, gives a single byte with code 3 and data 0x00.
- R6: No byte is emitted for a frame that lacks exactly seven 0x55 bytes followed by 0xD5, or whose strobe drops before the delimiter. The rest of such a frame is ignored until the strobe is low, and the next well-formed frame is then received normally.
- R7: If a frame byte is due while the output register is full and ready is low, the held byte is delivered unchanged. One byte with code 3 and data 0x00 follows it. Nothing more from that frame is emitted, and the next frame is received normally.
- R8: While valid is high and ready is low, valid stays high and the code and data stay unchanged.
- R9: During reset, out_valid is low.
- R10: Frames separated by a single low-strobe cycle are both received in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_dv | input | 1 | Receive data-valid strobe |
| rx_data | input | 8 | Receive byte |
| out_valid | output | 1 | Output byte available (source ready) |
| out_ready | input | 1 | Downstream accepts a byte (destination ready) |
| out_code | output | 2 | Packet code of the output byte |
| out_data | output | 8 | Output byte |

## Verification
The bench builds the block with its default parameters: a seven-byte lead-in and a four-byte check field, which gives a five-byte holding window. With these values, payloads of one to twenty bytes exercise the single-byte and short-frame paths as well as long packets. Lead-ins of three, five and eight bytes, and a wrong delimiter, are all within reach. Holding ready low across a whole frame makes the second payload byte meet a full register, so the truncation point is the same on every run.

// File: rtl/gmii_rx_pkg.sv
package gmii_rx_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    CODE_DATA = 2'd0,
    CODE_SOP  = 2'd1,
    CODE_GOOD = 2'd2,
    CODE_BAD  = 2'd3
  } pkt_code_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEADIN,
    ST_BODY,
    ST_DROP
  } rx_state_e;

  // One byte of a reflected CRC, least significant bit first.
  function automatic logic [31:0] crc_step(input logic [31:0] c,
                                           input logic [BYTE_W-1:0] d,
                                           input logic [31:0] poly);
    logic [31:0] r;
    r = c ^ {{(32-BYTE_W){1'b0}}, d};
    for (int b = 0; b < BYTE_W; b++) begin
      r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/gmii_rx_crc.sv
module gmii_rx_crc
  import gmii_rx_pkg::*;
#(
  parameter logic [31:0] POLY    = 32'hEDB88320,
  parameter logic [31:0] INIT    = 32'hFFFFFFFF,
  parameter logic [31:0] RESIDUE = 32'hDEBB20E3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              en,
  input  logic [BYTE_W-1:0] din,
  output logic              match
);
  logic [31:0] crc_q;
  logic [31:0] crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clear)   crc_d = INIT;
    else if (en) crc_d = crc_step(crc_q, din, POLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= INIT;
    else        crc_q <= crc_d;
  end

  assign match = (crc_q == RESIDUE);
endmodule

// File: rtl/gmii_rx_delay.sv
module gmii_rx_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic [W-1:0] oldest,
  output logic         full
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  taps [DEPTH];
  logic [CW-1:0] fill_q;
  logic [CW-1:0] fill_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_tap
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    taps[0] <= '0;
        else if (push) taps[0] <= din;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    taps[i] <= '0;
        else if (push) taps[i] <= taps[i-1];
      end
    end
  end

  assign full = (fill_q == CW'(DEPTH));

  always_comb begin
    fill_d = fill_q;
    if (clear)              fill_d = '0;
    else if (push && !full) fill_d = fill_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_q <= '0;
    else        fill_q <= fill_d;
  end

  assign oldest = taps[DEPTH-1];
endmodule

// File: rtl/gmii_rx_outreg.sv
module gmii_rx_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [1:0]   ld_code,
  input  logic [W-1:0] ld_data,
  input  logic         ready,
  output logic         valid,
  output logic [1:0]   code,
  output logic [W-1:0] data,
  output logic         free
);
  assign free = !valid || ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      code  <= 2'd0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      code  <= ld_code;
      data  <= ld_data;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/gmii_rx_framer.sv
module gmii_rx_framer
  import gmii_rx_pkg::*;
#(
  parameter int                LEAD_LEN  = 7,
  parameter int                FCS_BYTES = 4,
  parameter logic [BYTE_W-1:0] LEAD_BYTE = 8'h55,
  parameter logic [BYTE_W-1:0] DELIM     = 8'hD5,
  parameter logic [31:0]       CRC_POLY  = 32'hEDB88320,
  parameter logic [31:0]       CRC_INIT  = 32'hFFFFFFFF,
  parameter logic [31:0]       CRC_RES   = 32'hDEBB20E3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_dv,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_code,
  output logic [BYTE_W-1:0] out_data
);
  localparam int WIN = FCS_BYTES + 1;
  localparam int LW  = $clog2(LEAD_LEN + 1);

  rx_state_e         state_q, state_n, state_d;
  logic [LW-1:0]     lead_q, lead_d;
  logic              first_q, first_n, first_d;
  logic              pend_q, pend_d;

  logic              want;
  pkt_code_e         w_code;
  logic [BYTE_W-1:0] w_data;
  logic              accept, trunc;
  logic              crc_clr, crc_en, crc_ok;
  logic              win_clr, win_push, win_full;
  logic [BYTE_W-1:0] win_old;
  logic              o_free, o_load;
  logic [1:0]        o_code;
  logic [BYTE_W-1:0] o_data;

  gmii_rx_crc #(.POLY(CRC_POLY), .INIT(CRC_INIT), .RESIDUE(CRC_RES)) u_crc (
    .clk(clk), .rst_n(rst_n), .clear(crc_clr), .en(crc_en),
    .din(rx_data), .match(crc_ok)
  );

  gmii_rx_delay #(.W(BYTE_W), .DEPTH(WIN)) u_win (
    .clk(clk), .rst_n(rst_n), .clear(win_clr), .push(win_push),
    .din(rx_data), .oldest(win_old), .full(win_full)
  );

  gmii_rx_outreg #(.W(BYTE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(o_load), .ld_code(o_code),
    .ld_data(o_data), .ready(out_ready), .valid(out_valid),
    .code(out_code), .data(out_data), .free(o_free)
  );

  // Frame sequencing
  always_comb begin
    state_n  = state_q;
    lead_d   = lead_q;
    first_n  = first_q;
    want     = 1'b0;
    w_code   = CODE_DATA;
    w_data   = win_old;
    crc_clr  = 1'b0;
    crc_en   = 1'b0;
    win_clr  = 1'b0;
    win_push = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (rx_dv) begin
          if (rx_data == LEAD_BYTE) begin
            lead_d  = LW'(1);
            state_n = ST_LEADIN;
          end else begin
            state_n = ST_DROP;
          end
        end
      end
      ST_LEADIN: begin
        if (!rx_dv) begin
          state_n = ST_IDLE;
        end else if (rx_data == LEAD_BYTE && lead_q < LW'(LEAD_LEN)) begin
          lead_d = lead_q + 1'b1;
        end else if (rx_data == DELIM && lead_q == LW'(LEAD_LEN)) begin
          state_n = ST_BODY;
          crc_clr = 1'b1;
          win_clr = 1'b1;
          first_n = 1'b1;
        end else begin
          state_n = ST_DROP;
        end
      end
      ST_BODY: begin
        if (rx_dv) begin
          crc_en   = 1'b1;
          win_push = 1'b1;
          if (win_full) begin
            want   = 1'b1;
            w_code = first_q ? CODE_SOP : CODE_DATA;
          end
        end else begin
          want    = 1'b1;
          state_n = ST_IDLE;
          if (win_full) begin
            w_code = crc_ok ? CODE_GOOD : CODE_BAD;
          end else begin
            w_code = CODE_BAD;
            w_data = '0;
          end
        end
      end
      ST_DROP: begin
        if (!rx_dv) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // Output arbitration and truncation
  assign accept  = want && o_free && !pend_q;
  assign trunc   = want && !accept;
  assign o_load  = accept || (pend_q && o_free);
  assign o_code  = accept ? w_code : CODE_BAD;
  assign o_data  = accept ? w_data : '0;
  assign pend_d  = trunc || (pend_q && !o_free);
  assign state_d = (trunc && rx_dv) ? ST_DROP : state_n;
  assign first_d = accept ? 1'b0 : first_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lead_q  <= '0;
      first_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      lead_q  <= lead_d;
      first_q <= first_d;
      pend_q  <= pend_d;
    end
  end
endmodule

// File: rtl/gmii_rx_framer_chk.sv
module gmii_rx_framer_chk
  import gmii_rx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rx_dv,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        out_code,
  input logic [BYTE_W-1:0] out_data
);
  logic in_pkt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt <= 1'b0;
    end else if (out_valid && out_ready) begin
      if (out_code == CODE_SOP)                              in_pkt <= 1'b1;
      else if (out_code == CODE_GOOD || out_code == CODE_BAD) in_pkt <= 1'b0;
    end
  end

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid); // R8

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_code) && $stable(out_data)); // R8

  AST_SOP_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_code == CODE_SOP |-> !in_pkt); // R1

  AST_DATA_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_code == CODE_DATA |-> in_pkt); // R1

  AST_GOOD_AFTER_DV: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!out_valid || out_ready) && out_valid && out_code == CODE_GOOD)
      |-> !$past(rx_dv)); // R2
endmodule

bind gmii_rx_framer gmii_rx_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .out_valid(out_valid),
  .out_ready(out_ready), .out_code(out_code), .out_data(out_data)
);

// File: tb/gmii_rx_framer_tb.sv
module gmii_rx_framer_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       rx_dv;
  logic [7:0] rx_data;
  logic       out_valid;
  logic       out_ready;
  logic [1:0] out_code;
  logic [7:0] out_data;

  int errors = 0;
  int checks = 0;
  int xfers  = 0;
  bit done   = 0;

  logic [9:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] pl    [$];
  logic [7:0] wq    [$];

  gmii_rx_framer u_dut (
    .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_data(rx_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_code(out_code), .out_data(out_data)
  );

  initial begin
    clk = 0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && out_valid && out_ready) begin
        xfers++;
        if (exp_q.size() == 0) begin
          check(0, "R1", "unexpected byte", {22'd0, out_code, out_data}, 32'h0);
        end else begin
          logic [9:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({out_code, out_data} == e, t, "code/data",
                {22'd0, out_code, out_data}, {22'd0, e});
        end
      end
    end
  end

  task automatic wire_byte(input bit dv, input logic [7:0] d);
    @(negedge clk);
    #1;
    rx_dv   = dv;
    rx_data = d;
  endtask

  task automatic set_ready(input bit r);
    @(negedge clk);
    #1;
    out_ready = r;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) wire_byte(0, 8'h00);
  endtask

  task automatic send(input int lead_n, input bit use_delim,
                      input logic [7:0] delim, input int gap);
    for (int i = 0; i < lead_n; i++) wire_byte(1, 8'h55);
    if (use_delim) wire_byte(1, delim);
    foreach (wq[i]) wire_byte(1, wq[i]);
    idle(gap);
  endtask

  // Payload plus check field, computed from the CRC definition.
  task automatic build(input int n, input int seed, input bit corrupt);
    logic [31:0] c;
    pl.delete();
    wq.delete();
    for (int i = 0; i < n; i++) pl.push_back(8'(seed * 7 + i * 13 + 1));
    c = 32'hFFFFFFFF;
    foreach (pl[i]) begin
      c = c ^ {24'd0, pl[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    c = ~c;
    foreach (pl[i]) wq.push_back(pl[i]);
    for (int k = 0; k < 4; k++) wq.push_back(c[8*k +: 8]);
    if (corrupt) wq[wq.size()-1] = wq[wq.size()-1] ^ 8'h01;
  endtask

  task automatic push_exp(input logic [1:0] code, input logic [7:0] d, input string t);
    exp_q.push_back({code, d});
    tag_q.push_back(t);
  endtask

  task automatic expect_pkt(input bit good, input string t);
    logic [1:0] ec;
    ec = good ? 2'd2 : 2'd3;
    if (pl.size() == 1) begin
      push_exp(ec, pl[0], t);
    end else begin
      foreach (pl[i]) begin
        if (i == 0)                  push_exp(2'd1, pl[i], t);
        else if (i == pl.size() - 1) push_exp(ec, pl[i], t);
        else                         push_exp(2'd0, pl[i], t);
      end
    end
  endtask

  task automatic sample_out(output logic v, output logic [1:0] c, output logic [7:0] d);
    @(negedge clk);
    #2;
    v = out_valid;
    c = out_code;
    d = out_data;
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    logic       v;
    logic [1:0] c;
    logic [7:0] d;
    int         snap;
    logic [7:0] held;

    rst_n = 0; rx_dv = 0; rx_data = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    #2;
    check(out_valid == 0, "R9", "valid in reset", {31'd0, out_valid}, 0);
    #1 rst_n = 1;
    idle(3);
    sample_out(v, c, d);
    check(v == 0, "R9", "valid after reset", {31'd0, v}, 0);

    // R1 / R2: good frames of several lengths
    build(6, 1, 0);  expect_pkt(1, "R1"); send(7, 1, 8'hD5, 12);
    build(20, 2, 0); expect_pkt(1, "R2"); send(7, 1, 8'hD5, 12);
    build(2, 3, 0);  expect_pkt(1, "R2"); send(7, 1, 8'hD5, 12);

    // R3: bad check field
    build(9, 4, 1); expect_pkt(0, "R3"); send(7, 1, 8'hD5, 12);

    // R4: one payload byte, good and bad
    build(1, 5, 0); expect_pkt(1, "R4"); send(7, 1, 8'hD5, 12);
    build(1, 6, 1); expect_pkt(0, "R4"); send(7, 1, 8'hD5, 12);

    // R5: short frames
    wq.delete(); wq.push_back(8'hA1); wq.push_back(8'hA2); wq.push_back(8'hA3);
    push_exp(2'd3, 8'h00, "R5"); send(7, 1, 8'hD5, 12);
    wq.delete(); wq.push_back(8'h11); wq.push_back(8'h22);
    wq.push_back(8'h33); wq.push_back(8'h44);
    push_exp(2'd3, 8'h00, "R5"); send(7, 1, 8'hD5, 12);
    wq.delete();
    push_exp(2'd3, 8'h00, "R5"); send(7, 1, 8'hD5, 12);

    // R6: malformed lead-ins emit nothing
    idle(10);
    snap = xfers;
    wq.delete(); send(3, 0, 8'hD5, 4);
    build(6, 7, 0); send(5, 1, 8'hD5, 6);
    build(6, 8, 0); send(8, 1, 8'hD5, 6);
    build(6, 9, 0); send(7, 1, 8'h5D, 6);
    build(6, 10, 0); send(0, 1, 8'hD5, 6);
    idle(10);
    check(xfers == snap, "R6", "bytes from bad lead-in", xfers, snap);
    check(exp_q.size() == 0, "R6", "pending expectations", exp_q.size(), 0);
    build(7, 11, 0); expect_pkt(1, "R6"); send(7, 1, 8'hD5, 12);

    // R7: ready low across a whole frame
    set_ready(0);
    build(12, 12, 0);
    held = pl[0];
    push_exp(2'd1, pl[0], "R7");
    push_exp(2'd3, 8'h00, "R7");
    send(7, 1, 8'hD5, 6);
    sample_out(v, c, d);
    check(v == 1 && c == 2'd1 && d == held, "R8", "held byte under stall",
          {22'd0, c, d}, {22'd0, 2'd1, held});
    set_ready(1);
    idle(6);
    check(exp_q.size() == 0, "R7", "truncated packet drained", exp_q.size(), 0);
    build(5, 13, 0); expect_pkt(1, "R7"); send(7, 1, 8'hD5, 12);

    // R8: stall on the end byte
    build(3, 14, 0); expect_pkt(1, "R8");
    held = pl[2];
    send(7, 1, 8'hD5, 1);
    set_ready(0);
    idle(3);
    sample_out(v, c, d);
    check(v == 1 && c == 2'd2 && d == held, "R8", "end byte held",
          {22'd0, c, d}, {22'd0, 2'd2, held});
    set_ready(1);
    idle(10);

    // R10: back-to-back frames
    build(4, 15, 0); expect_pkt(1, "R10"); send(7, 1, 8'hD5, 1);
    build(7, 16, 1); expect_pkt(0, "R10"); send(7, 1, 8'hD5, 1);
    build(10, 17, 0); expect_pkt(1, "R10"); send(7, 1, 8'hD5, 12);

    idle(30);
    check(exp_q.size() == 0, "R1", "all expected bytes seen", exp_q.size(), 0);
    done = 1;
    finish_run();
  end
endmodule